// File: doc/BRIEF.md
# MDIO Management Serial Slave

This block is the slave end of a two-wire management port. It is clocked by the management clock MDC and samples the shared data line on each rising edge. A frame is accepted only after at least 32 consecutive ones, called the preamble. The block then decodes the header: the start pattern, the read/write opcode, a five-bit device address and a five-bit register address. Two turnaround bit times follow. In the data phase the block either shifts 16 bits in and writes them to a register file, or shifts the addressed register out onto the line with the most significant bit first.

The device address is tied to five strap pins. Their values are captured while reset is held, and a frame is accepted only when its device field equals the bitwise inverse of the captured value. A burst mode is available through a configuration input. When it is set, a read of register address 11111 streams all eleven implemented registers in one 176-bit data phase, in the order 0 to 5 and then 16 to 20. The registers live outside the block and are reached through a parallel port that carries an address, combinational read data and a one-cycle write strobe.

Top module: `mdio_slave`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `mdioOe` and `rfWrEn` are 0.
- R2: A frame is recognised only after at least 32 consecutive ones have been sampled. With 31 ones or fewer, the frame that follows gets no response. Any number of ones from 32 upward is accepted.
- R3: After the preamble, the first 0 is taken as the first start bit. The next bit must be 1, or the frame is dropped with no response.
- R4: Opcode 10 (sent first bit first) is a read and 01 is a write. Opcodes 00 and 11 drop the frame: no write strobe and no drive.
- R5: A frame is served only when its device field equals the bitwise inverse of `strapPins` as captured during reset. Changing `strapPins` after reset has no effect.
- R6: On a read, `mdioOe` rises after the 15th frame bit with `mdioOut`=0. After frame bit 16+j the block presents data bit j, most significant bit first. `mdioOe` falls after the last data bit.
- R7: On a write, the 16 data bits are taken most significant bit first. In the cycle after the 32nd frame bit, `rfWrEn` is 1 for one cycle with `rfAddr` set to the register address and `rfWrData` set to the data.
- R8: With `burstEn`=1, a read of register address 11111 has a 176-bit data phase. It carries registers 0,1,2,3,4,5,16,17,18,19,20 in that order.
- R9: With `burstEn`=0, a read of address 11111 is an ordinary 16-bit read of register file address 31.
- R10: A write to register address 11111 produces no `rfWrEn`, whether or not `burstEn` is set.
- R11: Every frame, including a dropped one, must be followed by a new preamble of at least 32 ones before another frame is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; strap pins are captured while it is low |
| mdioIn | input | 1 | Sampled value of the data line |
| mdioOut | output | 1 | Value driven onto the data line when enabled |
| mdioOe | output | 1 | Output enable for the data line |
| strapPins | input | 5 | Address strap pins, captured during reset |
| burstEn | input | 1 | Enables the all-register burst on reads of address 11111 |
| rfAddr | output | 5 | Register file address for the current read word or write |
| rfRdData | input | 16 | Combinational read data for `rfAddr` |
| rfWrEn | output | 1 | One-cycle write strobe |
| rfWrData | output | 16 | Write data presented with `rfWrEn` |

## Verification
Reads and writes use all-ones, all-zeros and mixed data words on low and high register addresses. This separates bit ordering and stuck bits from address steering. Preambles of 31, 32, 40 and 8 ones mark the edge of frame acceptance, both after reset and right after a completed frame. Frames with a bad start bit, with opcodes 00 and 11, and with the raw strap value as device address must each leave the line and the write strobe idle. Reads of address 11111 with the burst mode on and off, and writes to that address, separate the 176-bit stream and its register order from an ordinary access.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [3:0] {
    ST_PRE,
    ST_START,
    ST_OP,
    ST_DEV,
    ST_REG,
    ST_TA1,
    ST_TA2,
    ST_RDAT,
    ST_WDAT
  } mdioState_e;

  // Strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic driveTa;
    logic loadWord;
    logic shiftOut;
    logic releaseBus;
    logic shiftIn;
    logic commitWr;
  } mdioStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 11,
  parameter int LOW_REGS  = 6,
  parameter int HIGH_BASE = 16,
  parameter int PRE_LEN   = 32
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  logic [ADDR_W-1:0] strapPins,
  input  logic              burstEn,
  output mdioStrobe_t       stb,
  output logic [ADDR_W-1:0] rfAddr,
  output logic              ctrlIdle
);

  localparam int BURST_BITS = NUM_REGS * DATA_W;
  localparam int CNT_W      = $clog2(BURST_BITS + 1);
  localparam int PRE_W      = $clog2(PRE_LEN + 1);
  localparam int WORD_BITS  = $clog2(DATA_W);
  localparam int FC_W       = $clog2(ADDR_W) + 1;
  localparam int HIGH_OFS   = HIGH_BASE - LOW_REGS;

  mdioState_e        state;
  logic [PRE_W-1:0]  oneCnt;
  logic [FC_W-1:0]   fieldCnt;
  logic [ADDR_W-1:0] fieldSh;
  logic [ADDR_W-1:0] fieldNext;
  logic [ADDR_W-1:0] regAddr;
  logic [ADDR_W-1:0] strapQ;
  logic              isRead;
  logic              burstQ;
  logic [CNT_W-1:0]  dataCnt;
  logic [CNT_W-1:0]  dataLen;
  logic [CNT_W-1:0]  wordIdx;
  logic [1:0]        opNext;
  logic              lastField;
  logic              wordStart;

  assign fieldNext = {fieldSh[ADDR_W-2:0], mdioIn};
  assign opNext    = {fieldSh[0], mdioIn};
  assign lastField = (fieldCnt == FC_W'(ADDR_W - 1));
  assign dataLen   = burstQ ? CNT_W'(BURST_BITS) : CNT_W'(DATA_W);
  assign wordStart = (dataCnt[WORD_BITS-1:0] == '0);
  assign wordIdx   = dataCnt >> WORD_BITS;
  assign ctrlIdle  = (state == ST_PRE);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PRE;
      oneCnt   <= '0;
      fieldCnt <= '0;
      fieldSh  <= '0;
      regAddr  <= '0;
      isRead   <= 1'b0;
      burstQ   <= 1'b0;
      dataCnt  <= '0;
      strapQ   <= strapPins;
    end else begin
      case (state)
        ST_PRE: begin
          if (mdioIn) begin
            if (oneCnt != PRE_W'(PRE_LEN)) oneCnt <= oneCnt + 1'b1;
          end else begin
            oneCnt <= '0;
            if (oneCnt == PRE_W'(PRE_LEN)) state <= ST_START;
          end
        end
        ST_START: begin
          fieldCnt <= '0;
          state    <= mdioIn ? ST_OP : ST_PRE;
        end
        ST_OP: begin
          fieldSh  <= fieldNext;
          fieldCnt <= fieldCnt + 1'b1;
          if (fieldCnt == FC_W'(1)) begin
            fieldCnt <= '0;
            isRead   <= (opNext == OP_READ);
            state    <= (opNext == OP_READ || opNext == OP_WRITE) ? ST_DEV : ST_PRE;
          end
        end
        ST_DEV: begin
          fieldSh  <= fieldNext;
          fieldCnt <= fieldCnt + 1'b1;
          if (lastField) begin
            fieldCnt <= '0;
            state    <= (fieldNext == ~strapQ) ? ST_REG : ST_PRE;
          end
        end
        ST_REG: begin
          fieldSh  <= fieldNext;
          fieldCnt <= fieldCnt + 1'b1;
          if (lastField) begin
            fieldCnt <= '0;
            regAddr  <= fieldNext;
            burstQ   <= isRead && burstEn && (fieldNext == '1);
            state    <= ST_TA1;
          end
        end
        ST_TA1: begin
          dataCnt <= '0;
          state   <= ST_TA2;
        end
        ST_TA2: begin
          if (isRead) begin
            dataCnt <= CNT_W'(1);
            state   <= ST_RDAT;
          end else begin
            state <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (dataCnt == dataLen) state <= ST_PRE;
          else dataCnt <= dataCnt + 1'b1;
        end
        ST_WDAT: begin
          dataCnt <= dataCnt + 1'b1;
          if (dataCnt == CNT_W'(DATA_W - 1)) state <= ST_PRE;
        end
        default: state <= ST_PRE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    case (state)
      ST_TA1: stb.driveTa  = isRead;
      ST_TA2: stb.loadWord = isRead;
      ST_RDAT: begin
        if (dataCnt == dataLen) stb.releaseBus = 1'b1;
        else if (wordStart)     stb.loadWord   = 1'b1;
        else                    stb.shiftOut   = 1'b1;
      end
      ST_WDAT: begin
        stb.shiftIn  = 1'b1;
        stb.commitWr = (dataCnt == CNT_W'(DATA_W - 1)) && (regAddr != '1);
      end
      default: stb = '0;
    endcase
  end

  always_comb begin
    if (!burstQ)                          rfAddr = regAddr;
    else if (wordIdx < CNT_W'(LOW_REGS))  rfAddr = ADDR_W'(wordIdx);
    else                                  rfAddr = ADDR_W'(wordIdx + CNT_W'(HIGH_OFS));
  end

  // R2: the start state is only reached from a full preamble
  p_full_preamble_r2: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_START) |-> ($past(oneCnt) == PRE_W'(PRE_LEN)));

  // R5: the register field is only collected after a matching device field
  p_dev_match_r5: assert property (@(posedge mdc) disable iff (!rstN)
    ((state == ST_REG) && ($past(state) == ST_DEV)) |-> ($past(fieldNext) == ~strapQ));

  // R8: the burst never applies to a write data phase
  p_burst_read_only_r8: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_WDAT) |-> !burstQ);

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  input  mdioStrobe_t       stb,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              rfWrEn,
  output logic [DATA_W-1:0] rfWrData
);

  logic [DATA_W-1:0] rdSh;
  logic [DATA_W-1:0] wrSh;

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      mdioOut  <= 1'b0;
      mdioOe   <= 1'b0;
      rfWrEn   <= 1'b0;
      rfWrData <= '0;
      rdSh     <= '0;
      wrSh     <= '0;
    end else begin
      rfWrEn <= 1'b0;
      if (stb.driveTa) begin
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end
      if (stb.loadWord) begin
        mdioOut <= rfRdData[DATA_W-1];
        rdSh    <= {rfRdData[DATA_W-2:0], 1'b0};
      end
      if (stb.shiftOut) begin
        mdioOut <= rdSh[DATA_W-1];
        rdSh    <= {rdSh[DATA_W-2:0], 1'b0};
      end
      if (stb.releaseBus) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b0;
      end
      if (stb.shiftIn) wrSh <= {wrSh[DATA_W-2:0], mdioIn};
      if (stb.commitWr) begin
        rfWrEn   <= 1'b1;
        rfWrData <= {wrSh[DATA_W-2:0], mdioIn};
      end
    end
  end

  // R7: the write strobe lasts exactly one cycle
  p_wr_single_r7: assert property (@(posedge mdc) disable iff (!rstN)
    rfWrEn |=> !rfWrEn);

  // R6: the first driven bit is the low turnaround bit
  p_ta_low_r6: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 11,
  parameter int LOW_REGS  = 6,
  parameter int HIGH_BASE = 16,
  parameter int PRE_LEN   = 32
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [ADDR_W-1:0] strapPins,
  input  logic              burstEn,
  output logic [ADDR_W-1:0] rfAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [DATA_W-1:0] rfWrData
);

  mdioStrobe_t stb;
  logic        ctrlIdle;

  mdio_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .LOW_REGS(LOW_REGS), .HIGH_BASE(HIGH_BASE), .PRE_LEN(PRE_LEN)
  ) uCtrl (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .strapPins(strapPins),
    .burstEn(burstEn), .stb(stb), .rfAddr(rfAddr), .ctrlIdle(ctrlIdle)
  );

  mdio_dp #(.DATA_W(DATA_W)) uDp (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .stb(stb), .rfRdData(rfRdData),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rfWrEn(rfWrEn), .rfWrData(rfWrData)
  );

  // R11: the line is released whenever the controller waits for a preamble
  p_idle_released_r11: assert property (@(posedge mdc) disable iff (!rstN)
    ctrlIdle |-> !mdioOe);

  // R10: the all-ones register address is never written
  p_no_wr_all_ones_r10: assert property (@(posedge mdc) disable iff (!rstN)
    rfWrEn |-> (rfAddr != '1));

endmodule

// File: tb/tb_mdio_slave.sv
`timescale 1ns/1ps
module tb_mdio_slave;

  localparam logic [4:0] STRAP_AT_RESET = 5'b10110;
  localparam logic [4:0] DEV_OK         = ~STRAP_AT_RESET;

  typedef struct packed {
    bit mIn;
    bit eOe;
    bit eOut;
    bit eWr;
  } step_t;

  logic        mdc = 1'b0;
  logic        rstN;
  logic        mdioIn;
  logic        mdioOut;
  logic        mdioOe;
  logic [4:0]  strapPins;
  logic        burstEn;
  logic [4:0]  rfAddr;
  logic [15:0] rfRdData;
  logic        rfWrEn;
  logic [15:0] rfWrData;

  logic [15:0] fileMem  [32];
  logic [15:0] modelMem [32];
  int testsRun    = 0;
  int testsFailed = 0;

  always #10 mdc = ~mdc;

  mdio_slave dut (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .strapPins(strapPins), .burstEn(burstEn), .rfAddr(rfAddr), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrData(rfWrData)
  );

  function automatic logic [15:0] seedWord(int i);
    return 16'(i * 16'h0911) ^ 16'hC35A;
  endfunction

  function automatic logic [4:0] burstAddr(int w);
    return (w < 6) ? 5'(w) : 5'(w + 10);
  endfunction

  // Register file seen by the block: combinational read, written on the strobe
  assign rfRdData = fileMem[rfAddr];
  always @(posedge mdc) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) fileMem[i] <= seedWord(i);
    end else if (rfWrEn) begin
      fileMem[rfAddr] <= rfWrData;
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareStep(input string tag, input step_t e, input logic [4:0] regA, input logic [15:0] wdata);
    check(mdioOe === e.eOe, tag, "mdioOe", int'(mdioOe), int'(e.eOe));
    if (e.eOe) check(mdioOut === e.eOut, tag, "mdioOut", int'(mdioOut), int'(e.eOut));
    check(rfWrEn === e.eWr, tag, "rfWrEn", int'(rfWrEn), int'(e.eWr));
    if (e.eWr) begin
      check(rfAddr === regA, tag, "rfAddr", int'(rfAddr), int'(regA));
      check(rfWrData === wdata, tag, "rfWrData", int'(rfWrData), int'(wdata));
    end
  endtask

  // Builds the master bit stream and the expected response per cycle, then plays it
  task automatic runFrame(input string tag, input int preLen, input logic [1:0] st,
                          input logic [1:0] op, input logic [4:0] dev, input logic [4:0] regA,
                          input logic [15:0] wdata);
    step_t       q[$];
    logic [15:0] words[$];
    logic [13:0] hdr;
    bit valid, isRd, isWr, burst;
    int n;
    valid = (preLen >= 32) && (st == 2'b01) && (op == 2'b10 || op == 2'b01) && (dev == DEV_OK);
    isRd  = valid && (op == 2'b10);
    isWr  = valid && (op == 2'b01);
    burst = isRd && (regA == 5'h1f) && burstEn;
    n     = burst ? 176 : 16;
    for (int w = 0; w < n / 16; w++) words.push_back(modelMem[burst ? burstAddr(w) : regA]);
    for (int i = 0; i < preLen; i++) q.push_back('{mIn: 1'b1, eOe: 1'b0, eOut: 1'b0, eWr: 1'b0});
    hdr = {st, op, dev, regA};
    for (int b = 13; b >= 0; b--) q.push_back('{mIn: hdr[b], eOe: 1'b0, eOut: 1'b0, eWr: 1'b0});
    q.push_back('{mIn: 1'b1, eOe: isRd, eOut: 1'b0, eWr: 1'b0});
    q.push_back('{mIn: !isWr, eOe: isRd, eOut: isRd && words[0][15], eWr: 1'b0});
    for (int j = 0; j < n; j++) begin
      bit nOe, nOut, nWr, mBit;
      mBit = isWr ? wdata[15 - j] : 1'b1;
      nOe  = isRd && (j + 1 < n);
      nOut = nOe ? words[(j + 1) / 16][15 - ((j + 1) % 16)] : 1'b0;
      nWr  = isWr && (j == 15) && (regA != 5'h1f);
      q.push_back('{mIn: mBit, eOe: nOe, eOut: nOut, eWr: nWr});
    end
    q.push_back('{mIn: 1'b0, eOe: 1'b0, eOut: 1'b0, eWr: 1'b0});
    for (int i = 0; i <= q.size(); i++) begin
      @(negedge mdc);
      if (i > 0) compareStep(tag, q[i-1], regA, wdata);
      if (i < q.size()) mdioIn = q[i].mIn;
    end
    if (isWr && regA != 5'h1f) modelMem[regA] = wdata;
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    testsFailed++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) modelMem[i] = seedWord(i);
    rstN = 1'b0; mdioIn = 1'b1; burstEn = 1'b0; strapPins = STRAP_AT_RESET;
    for (int i = 0; i < 3; i++) begin
      @(negedge mdc);
      check(mdioOe === 1'b0, "R1", "mdioOe in reset", int'(mdioOe), 0);
      check(rfWrEn === 1'b0, "R1", "rfWrEn in reset", int'(rfWrEn), 0);
    end
    rstN = 1'b1;
    @(negedge mdc);
    check(mdioOe === 1'b0 && rfWrEn === 1'b0, "R1", "outputs after reset", int'({mdioOe, rfWrEn}), 0);
    strapPins = DEV_OK;  // R5: later pin changes must not matter

    runFrame("R7", 32, 2'b01, 2'b01, DEV_OK, 5'd3,  16'h1234);
    runFrame("R6", 32, 2'b01, 2'b10, DEV_OK, 5'd3,  16'h0);
    runFrame("R7", 32, 2'b01, 2'b01, DEV_OK, 5'd17, 16'hBEEF);
    runFrame("R6", 32, 2'b01, 2'b10, DEV_OK, 5'd17, 16'h0);
    runFrame("R7", 32, 2'b01, 2'b01, DEV_OK, 5'd0,  16'hFFFF);
    runFrame("R6", 32, 2'b01, 2'b10, DEV_OK, 5'd0,  16'h0);
    runFrame("R7", 32, 2'b01, 2'b01, DEV_OK, 5'd5,  16'h0000);
    runFrame("R6", 32, 2'b01, 2'b10, DEV_OK, 5'd5,  16'h0);
    runFrame("R7", 32, 2'b01, 2'b01, DEV_OK, 5'd20, 16'hA5C3);
    runFrame("R6", 32, 2'b01, 2'b10, DEV_OK, 5'd20, 16'h0);

    runFrame("R2", 31, 2'b01, 2'b10, DEV_OK, 5'd3,  16'h0);
    runFrame("R2", 31, 2'b01, 2'b01, DEV_OK, 5'd4,  16'h5555);
    runFrame("R2", 40, 2'b01, 2'b10, DEV_OK, 5'd3,  16'h0);

    runFrame("R3", 32, 2'b00, 2'b10, DEV_OK, 5'd3,  16'h0);
    runFrame("R4", 32, 2'b01, 2'b00, DEV_OK, 5'd3,  16'h0);
    runFrame("R4", 32, 2'b01, 2'b11, DEV_OK, 5'd2,  16'h9999);
    runFrame("R4", 32, 2'b01, 2'b10, DEV_OK, 5'd2,  16'h0);

    runFrame("R5", 32, 2'b01, 2'b10, STRAP_AT_RESET, 5'd3, 16'h0);
    runFrame("R5", 32, 2'b01, 2'b01, STRAP_AT_RESET, 5'd3, 16'h7E7E);
    runFrame("R5", 32, 2'b01, 2'b10, 5'b01000,       5'd3, 16'h0);
    runFrame("R5", 32, 2'b01, 2'b10, DEV_OK,         5'd3, 16'h0);

    runFrame("R10", 32, 2'b01, 2'b01, DEV_OK, 5'h1f, 16'h7777);
    runFrame("R9",  32, 2'b01, 2'b10, DEV_OK, 5'h1f, 16'h0);

    burstEn = 1'b1;
    runFrame("R7",  32, 2'b01, 2'b01, DEV_OK, 5'd16, 16'h0F0F);
    runFrame("R8",  32, 2'b01, 2'b10, DEV_OK, 5'h1f, 16'h0);
    runFrame("R8",  32, 2'b01, 2'b10, DEV_OK, 5'd4,  16'h0);
    runFrame("R10", 32, 2'b01, 2'b01, DEV_OK, 5'h1f, 16'h1111);
    runFrame("R8",  34, 2'b01, 2'b10, DEV_OK, 5'h1f, 16'h0);
    burstEn = 1'b0;

    runFrame("R11", 32, 2'b01, 2'b10, DEV_OK, 5'd1,  16'h0);
    runFrame("R11", 8,  2'b01, 2'b10, DEV_OK, 5'd1,  16'h0);
    runFrame("R11", 32, 2'b01, 2'b00, DEV_OK, 5'd1,  16'h0);
    runFrame("R11", 12, 2'b01, 2'b01, DEV_OK, 5'd1,  16'h4321);
    runFrame("R11", 32, 2'b01, 2'b10, DEV_OK, 5'd1,  16'h0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule